// File: doc/BRIEF.md
# Oscillator Amplitude Search Controller

This block sets the bias-current code of a crystal oscillator so that the oscillation amplitude ends up between two thresholds. Two comparator flags feed it: `amp_low` means the amplitude is under the lower threshold and more current is needed. `amp_high` means it is over the upper threshold and less current is needed. The controller runs from the oscillator's own clock, so it only advances once oscillation has started.

A search starts at midscale and moves the code by a step that halves after every update, which is a binary search. The amplitude reacts slowly to a change in bias, so every decision waits for a programmable settling count. The default of 75,000 cycles is 3 ms at 25 MHz.

The search stops early when neither flag is set. It also stops once the smallest step has been applied and has settled. Either way the code is then frozen and `done` is raised. A boost output speeds up start-up and drops when the search first acts. A new search begins only after reset or a `restart` pulse.

The machine has two states. ST_SEARCH counts out the settling interval and decides at its end. ST_HOLD freezes the code. There are two transitions:
- ST_SEARCH to ST_HOLD on the "finish" decision (window reached or step exhausted).
- Any state back to ST_SEARCH on `restart`.

Top module: `amp_search_ctrl`

## Requirements
- R1: After reset or a cycle with `restart` high, `bias_code` is 128 and the pending step is 64. `boost` is 1, and `done` and `err` are 0.
- R2: A decision is taken only on the clock edge that ends a settling interval of SETTLE_CYCLES edges. The first interval is counted from reset release or `restart`, and each later one from the previous decision. Between decisions `bias_code` does not change.
- R3: At a decision with `amp_low`=1, `amp_high`=0 and a nonzero step, the code rises by the step. The first rise from 128 gives 192.
- R4: At a decision with `amp_high`=1, `amp_low`=0 and a nonzero step, the code falls by the step. After any rise or fall the step halves, so 192 falls to 160.
- R5: At a decision with both flags 0, the search ends and `done` becomes 1. The code keeps its last value.
- R6: Once the step-1 update has been applied, the next decision ends the search with `done`=1 whatever the flags are. With the amplitude always low this gives 255, and with it always high this gives 1.
- R7: At a decision with both flags 1 and a nonzero step, `err` becomes 1 and the code is unchanged. The search continues with the same step. `err` stays 1 until reset or `restart`.
- R8: `boost` stays 1 until the first code update or the end of the search, whichever comes first, and is 0 afterwards.
- R9: While `done` is 1, the flags have no effect. `bias_code` and `done` hold until reset or `restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock taken from the running oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous request to start a new search |
| amp_low | input | 1 | Amplitude under lower threshold (raise bias) |
| amp_high | input | 1 | Amplitude over upper threshold (lower bias) |
| bias_code | output | CODE_W | Registered bias-current code |
| boost | output | 1 | Start-up current boost enable |
| done | output | 1 | Search finished, code frozen |
| err | output | 1 | Both flags were seen high at a decision |

## Verification
The in-line assertions check these on every cycle:
- the code is stable outside decision edges;
- a rise, a fall or an invalid-flag decision moves the code the right way, or leaves it alone;
- `done` and the code stay frozen once the search has ended;
- `done` never appears with `boost` still set.

Some behaviour only the bench scenarios can show, by comparing against a behavioural model with a delayed amplitude response on every clock:
- the exact code sequence 128, 192, 160, 176, 168;
- the termination at 255 and at 1 when no window is reachable;
- error stickiness across a later in-window finish;
- the effect of `restart`.

// File: rtl/amp_search_pkg.sv
package amp_search_pkg;
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_HOLD   = 1'b1
    } srch_state_e;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CYCLES = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && !clear && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the count never passes the interval end
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/code_stepper.sv
module code_stepper #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              apply,
    input  logic              dir_up,
    output logic [CODE_W-1:0] code,
    output logic              step_zero
);
    localparam logic [CODE_W-1:0] MID_CODE   = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] FIRST_STEP = CODE_W'(1) << (CODE_W - 2);

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] step_q;

    assign code      = code_q;
    assign step_zero = (step_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= MID_CODE;
            step_q <= FIRST_STEP;
        end else if (init) begin
            code_q <= MID_CODE;
            step_q <= FIRST_STEP;
        end else if (apply && !step_zero) begin
            code_q <= dir_up ? (code_q + step_q) : (code_q - step_q);
            step_q <= step_q >> 1;
        end
    end

    // R4: the step is always a single power of two or exhausted
    a_r4_step_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_q));
endmodule

// File: rtl/amp_search_ctrl.sv
module amp_search_ctrl #(
    parameter int CODE_W        = 8,
    parameter int SETTLE_CYCLES = 75000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              amp_low,
    input  logic              amp_high,
    output logic [CODE_W-1:0] bias_code,
    output logic              boost,
    output logic              done,
    output logic              err
);
    import amp_search_pkg::*;

    srch_state_e state_q, state_d;
    logic expire, step_zero, decide, flags_bad, in_window, finish, apply_upd;
    logic searching;

    assign searching = (state_q == ST_SEARCH);
    assign decide    = searching && expire && !restart;
    assign flags_bad = amp_low && amp_high;
    assign in_window = !amp_low && !amp_high;
    assign finish    = decide && (step_zero || in_window);
    assign apply_upd = decide && !step_zero && !flags_bad && !in_window;

    settle_timer #(.CYCLES(SETTLE_CYCLES)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .run    (searching),
        .expire (expire)
    );

    code_stepper #(.CODE_W(CODE_W)) stepper_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (restart),
        .apply     (apply_upd),
        .dir_up    (amp_low),
        .code      (bias_code),
        .step_zero (step_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEARCH: if (restart) state_d = ST_SEARCH;
                       else if (finish) state_d = ST_HOLD;
            ST_HOLD:   if (restart) state_d = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEARCH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boost <= 1'b1;
            done  <= 1'b0;
            err   <= 1'b0;
        end else if (restart) begin
            boost <= 1'b1;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            if (apply_upd || finish) boost <= 1'b0;
            if (finish) done <= 1'b1;
            if (decide && !step_zero && flags_bad) err <= 1'b1;
        end
    end

    // R2: no code movement off a decision edge
    a_r2_code_stable: assert property (@(posedge clk) disable iff (!rst_n || restart)
        !expire |=> $stable(bias_code));
    // R3: a low-amplitude decision raises the code
    a_r3_code_rises: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (searching && expire && amp_low && !amp_high && !step_zero) |=> (bias_code > $past(bias_code)));
    // R4: a high-amplitude decision lowers the code
    a_r4_code_falls: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (searching && expire && amp_high && !amp_low && !step_zero) |=> (bias_code < $past(bias_code)));
    // R7: invalid flags flag an error and leave the code
    a_r7_bad_flags: assert property (@(posedge clk) disable iff (!rst_n || restart)
        (searching && expire && flags_bad && !step_zero) |=> (err && $stable(bias_code)));
    // R9: finished state is frozen
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n || restart)
        done |=> (done && $stable(bias_code)));
    // R8: boost is gone once the search has ended
    a_r8_boost_off: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !boost);
endmodule

// File: tb/amp_search_ctrl_tb_top.sv
module amp_search_ctrl_tb_top;
    localparam int S = 20;
    localparam int DLY = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0;
    logic amp_low = 1'b0;
    logic amp_high = 1'b0;
    logic [7:0] bias_code;
    logic boost, done, err;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    int mode = 0;
    int win_lo = 0;
    int win_hi = 255;
    int hist[$];

    int m_code = 128, m_step = 64, m_cnt = 0;
    bit m_boost = 1, m_done = 0, m_err = 0;

    always #4 clk = ~clk;

    amp_search_ctrl #(.CODE_W(8), .SETTLE_CYCLES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .amp_low(amp_low), .amp_high(amp_high),
        .bias_code(bias_code), .boost(boost), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n || restart) begin
            m_code = 128; m_step = 64; m_cnt = 0;
            m_boost = 1; m_done = 0; m_err = 0;
        end else if (!m_done) begin
            if (m_cnt == S - 1) begin
                m_cnt = 0;
                if (m_step == 0 || (!amp_low && !amp_high)) begin
                    m_done = 1; m_boost = 0;
                end else if (amp_low && amp_high) begin
                    m_err = 1;
                end else begin
                    m_code = amp_low ? m_code + m_step : m_code - m_step;
                    m_step = m_step / 2;
                    m_boost = 0;
                end
            end else begin
                m_cnt++;
            end
        end
    end

    // compare every cycle, then drive the amplitude model
    always @(negedge clk) begin
        int amp;
        check(bias_code == m_code[7:0], "R3/R4 code", bias_code, m_code);
        check(boost == m_boost, "R8 boost", boost, m_boost);
        check(done == m_done, "R5 done", done, m_done);
        check(err == m_err, "R7 err", err, m_err);
        hist.push_front(int'(bias_code));
        if (hist.size() > 8) void'(hist.pop_back());
        amp = (hist.size() > DLY) ? hist[DLY] : 128;
        if (mode == 1) begin
            amp_low <= 1'b1; amp_high <= 1'b1;
        end else begin
            amp_low  <= (amp < win_lo);
            amp_high <= (amp > win_hi);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            bad++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    endtask

    task automatic do_restart();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
    endtask

    initial begin
        win_lo = 165; win_hi = 175; mode = 0;
        ticks(3);
        // R1 reset state
        check(bias_code == 8'd128, "R1 code", bias_code, 128);
        check(boost && !done && !err, "R1 flags", {boost, done, err}, 3'b100);
        rst_n = 1'b1;
        // R2 first decision after S edges
        ticks(S - 1);
        check(bias_code == 8'd128, "R2 before expiry", bias_code, 128);
        ticks(1);
        check(bias_code == 8'd192, "R3 first rise", bias_code, 192);
        check(!boost, "R8 boost cleared", boost, 0);
        ticks(S);
        check(bias_code == 8'd160, "R4 fall by 32", bias_code, 160);
        wait_done();
        check(done && bias_code == 8'd168, "R5 in-window stop", bias_code, 168);
        // R9 flags ignored after done
        mode = 1;
        ticks(3 * S);
        check(done && bias_code == 8'd168 && !err, "R9 hold", bias_code, 168);

        // R1 restart, then R6 unreachable high target
        mode = 0; win_lo = 300; win_hi = 310;
        do_restart();
        check(bias_code == 8'd128 && boost && !done, "R1 restart", bias_code, 128);
        wait_done();
        check(done && bias_code == 8'd255, "R6 top end", bias_code, 255);

        // R7 invalid flags
        mode = 1;
        do_restart();
        ticks(S + 2);
        check(err && bias_code == 8'd128, "R7 err hold", bias_code, 128);
        check(boost, "R8 boost kept on err", boost, 1);
        mode = 0; win_lo = 120; win_hi = 140;
        wait_done();
        check(done && err && bias_code == 8'd128, "R7 sticky", {done, err}, 2'b11);
        check(!boost, "R8 boost off at finish", boost, 0);

        // R6 unreachable low target, R1 err cleared
        win_lo = 0; win_hi = 0;
        do_restart();
        check(!err, "R1 err cleared", err, 0);
        wait_done();
        check(done && bias_code == 8'd1, "R6 bottom end", bias_code, 1);

        ticks(5);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule